// File: doc/BRIEF.md
# Interrupt Vector Dispatcher

This block watches 64 level-sensitive interrupt inputs and raises at most one of 64 vector request lines at a time. Inputs 0 to 31 come from expansion-slot devices. They are gated in groups of four, and each group has one mapping register. Inputs 32 to 63 come from on-board sources, and each of them has its own mapping register. Only the top bit of a mapping register is acted on. It enables the sources that the register covers. The remaining bits hold fixed routing values that software can read but not change.

A single pending-vector register records which request is outstanding. The register holds either a vector number or a "none" code. While a request is outstanding, a rearbitration keeps the same vector and does not pick a new one. Software removes the request in one of three ways: by disabling the matching mapping register, by writing the slot-group clear register for its group, or by writing the on-board clear register for its exact source. Each removal triggers a new ascending-order scan. Rising edges are treated differently by source type. A rising slot input in an enabled group takes the line at once. A rising on-board input takes the line only when the line is idle.

Register accesses are 32 bits wide. Each register occupies a 64-bit slot, and only the odd word (address bit 2 set) of that slot has any effect. Address bits 9:8 select the region: 0 is slot mapping, 1 is on-board mapping, 2 is slot clear, and 3 is on-board clear.

Top module: `irq_vector_dispatch`

## Requirements
- R1: At most one bit of `vec_req` is high. That bit is the pending vector. It changes in the clock cycle after the edge at which the cause is sampled.
- R2: A read of a mapping register returns the enable in bit 31 and a fixed value in bits 30:0. For slot group g (register index in address bits 7:3, g below 8) the fixed value is 0x7C0 | 4g. For on-board source n (index in bits 7:3) it is 0x7E0 + n. A write changes only bit 31.
- R3: A write to an even word (address bit 2 clear) has no effect. A read of an even word, or of either clear region, returns zero.
- R4: A mapping-register write made while no request is pending starts a scan. The scan takes inputs 0 to 63 in ascending order and grants the first input that has a latched high level and is enabled. Slot input i is enabled by slot group i/4.
- R5: A mapping-register write made while a request is pending keeps that same vector.
- R6: A mapping write with bit 31 clear drops the pending request when the pending vector equals the register index (slot index g for the slot region, n+32 for the on-board region). The scan then runs again. A slot group can be disabled without dropping its own pending input when that input's number differs from the group index.
- R7: A slot clear write, with the group index in address bits 7:5, drops the pending request when the pending vector divided by 4 equals that index. The scan then runs again. A clear that does not match does nothing.
- R8: An on-board clear write for source n drops the pending request only when the pending vector is exactly n+32. The scan then runs again.
- R9: A rising slot input whose group is enabled takes the request line even while another request is pending. When several slot inputs rise in the same cycle, the lowest-numbered one wins.
- R10: A rising on-board input takes the line only when nothing is pending after that cycle's register write and its own register is enabled.
- R11: Reset clears all enables, all latched input levels and all request lines, and it sets the pending register to "none".
- R12: Inputs that stay high grant nothing without a rising edge or a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 64 | Level interrupt inputs; 0-31 slot, 32-63 on-board |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 10 | Read byte address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| vec_req | output | 64 | Registered vector request lines |

## Verification
The hardest state to reach is a request that stays outstanding while its own enable is already off. It takes an exact sequence of steps: a slot input must be granted, and then a group register whose index differs from the pending vector number must be disabled. Stimulus that only follows ports seldom lines these up. Directed steps build this state on purpose. They also build preemption by simultaneous slot rises and an on-board rise that is held off by a pending request. A seeded random phase then mixes edges, clears and odd- and even-word writes, and a cycle-accurate bench model checks every step.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   typedef enum logic [1:0] {
      RGN_SLOT_MAP  = 2'd0,
      RGN_BOARD_MAP = 2'd1,
      RGN_SLOT_CLR  = 2'd2,
      RGN_BOARD_CLR = 2'd3
   } irqd_region_e;

   localparam logic [31:0] MAP_FIXED_BASE = 32'h0000_07C0;
   localparam logic [31:0] MAP_BOARD_TAG  = 32'h0000_0020;
endpackage

// File: rtl/irqd_first_set.sv
module irqd_first_set #(
   parameter int W = 32,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  req,
   output logic          hit,
   output logic [IW-1:0] pos
);
   initial begin
      if (W < 2) $error("irqd_first_set: W must be at least 2");
   end

   always_comb begin
      hit = 1'b0;
      pos = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            hit = 1'b1;
            pos = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irqd_map_regs.sv
module irqd_map_regs
   import irqd_pkg::*;
#(
   parameter int SLOT_GROUPS = 8,
   parameter int BOARD_SRCS  = 32,
   parameter int GROUP_SIZE  = 4,
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 32,
   localparam int FLD_W = ADDR_W - 5,
   localparam int SG_W  = $clog2(SLOT_GROUPS),
   localparam int BS_W  = $clog2(BOARD_SRCS)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   sel_slot_map,
   output logic                   sel_board_map,
   output logic                   sel_slot_clr,
   output logic                   sel_board_clr,
   output logic [FLD_W-1:0]       map_idx,
   output logic [FLD_W-3:0]       clr_grp,
   output logic                   wr_enable_bit,
   output logic [SLOT_GROUPS-1:0] slot_en_d,
   output logic [BOARD_SRCS-1:0]  board_en_d
);
   initial begin
      if (SLOT_GROUPS < 2) $error("irqd_map_regs: need at least two slot groups");
      if (BOARD_SRCS < 2) $error("irqd_map_regs: need at least two board sources");
      if ((1 << (FLD_W - 2)) < SLOT_GROUPS) $error("irqd_map_regs: clear index field too narrow");
      if ((1 << FLD_W) < BOARD_SRCS) $error("irqd_map_regs: map index field too narrow");
      if (DATA_W < 12) $error("irqd_map_regs: data too narrow for fixed fields");
   end

   logic [SLOT_GROUPS-1:0] slot_en_q;
   logic [BOARD_SRCS-1:0]  board_en_q;
   irqd_region_e           wr_rgn, rd_rgn;
   logic                   odd_wr;
   logic [FLD_W-1:0]       rd_idx;
   logic                   unused_addr_bits;

   assign wr_rgn        = irqd_region_e'(wr_addr[ADDR_W-1 -: 2]);
   assign rd_rgn        = irqd_region_e'(rd_addr[ADDR_W-1 -: 2]);
   assign odd_wr        = wr_en && wr_addr[2];
   assign map_idx       = wr_addr[3 +: FLD_W];
   assign clr_grp       = wr_addr[5 +: FLD_W-2];
   assign rd_idx        = rd_addr[3 +: FLD_W];
   assign wr_enable_bit = wr_data[DATA_W-1];
   assign unused_addr_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data[DATA_W-2:0]};

   assign sel_slot_map  = odd_wr && (wr_rgn == RGN_SLOT_MAP)  && (32'(map_idx) < SLOT_GROUPS);
   assign sel_board_map = odd_wr && (wr_rgn == RGN_BOARD_MAP) && (32'(map_idx) < BOARD_SRCS);
   assign sel_slot_clr  = odd_wr && (wr_rgn == RGN_SLOT_CLR)  && (32'(clr_grp) < SLOT_GROUPS);
   assign sel_board_clr = odd_wr && (wr_rgn == RGN_BOARD_CLR) && (32'(map_idx) < BOARD_SRCS);

   // Next enables: only bit DATA_W-1 of a mapping write is stored.
   always_comb begin
      slot_en_d  = slot_en_q;
      board_en_d = board_en_q;
      if (sel_slot_map)  slot_en_d[map_idx[SG_W-1:0]]  = wr_enable_bit;
      if (sel_board_map) board_en_d[map_idx[BS_W-1:0]] = wr_enable_bit;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_en_q  <= '0;
         board_en_q <= '0;
      end else begin
         slot_en_q  <= slot_en_d;
         board_en_q <= board_en_d;
      end
   end

   // Readback: fixed routing fields are constants computed from the index.
   always_comb begin
      rd_data = '0;
      if (rd_addr[2]) begin
         unique case (rd_rgn)
            RGN_SLOT_MAP: if (32'(rd_idx) < SLOT_GROUPS)
               rd_data = {slot_en_q[rd_idx[SG_W-1:0]],
                          (DATA_W-1)'(MAP_FIXED_BASE | (32'(rd_idx) * GROUP_SIZE))};
            RGN_BOARD_MAP: if (32'(rd_idx) < BOARD_SRCS)
               rd_data = {board_en_q[rd_idx[BS_W-1:0]],
                          (DATA_W-1)'((MAP_FIXED_BASE | MAP_BOARD_TAG) + 32'(rd_idx))};
            default: rd_data = '0;
         endcase
      end
   end

   // R3: an even-word write leaves every enable unchanged.
   assert_even_word_ignored_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_addr[2]) |=> ($stable(slot_en_q) && $stable(board_en_q)));
endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch #(
   parameter int SLOT_GROUPS = 8,
   parameter int GROUP_SIZE  = 4,
   parameter int BOARD_SRCS  = 32,
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 32,
   localparam int N_SLOT = SLOT_GROUPS * GROUP_SIZE,
   localparam int N_IN   = N_SLOT + BOARD_SRCS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_IN-1:0]   irq_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [N_IN-1:0]   vec_req
);
   localparam int VEC_W = $clog2(N_IN + 2);
   localparam int FLD_W = ADDR_W - 5;
   localparam int GS_SH = $clog2(GROUP_SIZE);
   localparam logic [VEC_W-1:0] NONE = VEC_W'(N_IN + 1);
   localparam int SW = $clog2(N_SLOT);
   localparam int BW = $clog2(BOARD_SRCS);
   localparam int AW = $clog2(N_IN);

   initial begin
      if ((1 << GS_SH) != GROUP_SIZE) $error("irq_vector_dispatch: GROUP_SIZE must be a power of two");
      if (N_SLOT < 2) $error("irq_vector_dispatch: too few slot inputs");
   end

   logic                   sel_slot_map, sel_board_map, sel_slot_clr, sel_board_clr;
   logic [FLD_W-1:0]       map_idx;
   logic [FLD_W-3:0]       clr_grp;
   logic                   wr_enable_bit;
   logic [SLOT_GROUPS-1:0] slot_en_d;
   logic [BOARD_SRCS-1:0]  board_en_d;
   logic [N_IN-1:0]        en_all_d, lvl, rise;
   logic [VEC_W-1:0]       pend, p_drop, p_scan, p_next;
   logic                   drop, rescan;
   logic                   scan_hit, srise_hit, brise_hit;
   logic [AW-1:0]          scan_pos;
   logic [SW-1:0]          srise_pos;
   logic [BW-1:0]          brise_pos;
   logic [N_IN-1:0]        vec_d;

   irqd_map_regs #(
      .SLOT_GROUPS(SLOT_GROUPS), .BOARD_SRCS(BOARD_SRCS), .GROUP_SIZE(GROUP_SIZE),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .sel_slot_map(sel_slot_map), .sel_board_map(sel_board_map),
      .sel_slot_clr(sel_slot_clr), .sel_board_clr(sel_board_clr),
      .map_idx(map_idx), .clr_grp(clr_grp), .wr_enable_bit(wr_enable_bit),
      .slot_en_d(slot_en_d), .board_en_d(board_en_d)
   );

   // Per-input enable view after this cycle's write.
   for (genvar i = 0; i < N_IN; i++) begin : g_en
      if (i < N_SLOT) begin : g_slot
         assign en_all_d[i] = slot_en_d[i / GROUP_SIZE];
      end else begin : g_board
         assign en_all_d[i] = board_en_d[i - N_SLOT];
      end
   end

   assign rise = irq_in & ~lvl;

   irqd_first_set #(.W(N_IN)) u_scan (
      .req(lvl & en_all_d), .hit(scan_hit), .pos(scan_pos));
   irqd_first_set #(.W(N_SLOT)) u_srise (
      .req(rise[N_SLOT-1:0] & en_all_d[N_SLOT-1:0]), .hit(srise_hit), .pos(srise_pos));
   irqd_first_set #(.W(BOARD_SRCS)) u_brise (
      .req(rise[N_IN-1:N_SLOT] & en_all_d[N_IN-1:N_SLOT]), .hit(brise_hit), .pos(brise_pos));

   // Step 1: register write may drop the pending vector.
   always_comb begin
      drop = 1'b0;
      if (sel_slot_map && !wr_enable_bit && (pend == VEC_W'(map_idx)))
         drop = 1'b1;
      if (sel_board_map && !wr_enable_bit && (pend == VEC_W'(map_idx) + VEC_W'(N_SLOT)))
         drop = 1'b1;
      if (sel_slot_clr && (pend != NONE) && ((pend >> GS_SH) == VEC_W'(clr_grp)))
         drop = 1'b1;
      if (sel_board_clr && (pend == VEC_W'(map_idx) + VEC_W'(N_SLOT)))
         drop = 1'b1;
      rescan = sel_slot_map || sel_board_map || drop;
      p_drop = drop ? NONE : pend;
   end

   // Step 2: rearbitrate; a still-pending vector is simply kept.
   assign p_scan = (rescan && (p_drop == NONE) && scan_hit) ? VEC_W'(scan_pos) : p_drop;

   // Step 3: rising edges; slot edges preempt, board edges only fill an idle line.
   always_comb begin
      p_next = p_scan;
      if (srise_hit)
         p_next = VEC_W'(srise_pos);
      else if (brise_hit && (p_scan == NONE))
         p_next = VEC_W'(brise_pos) + VEC_W'(N_SLOT);
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_dec
      assign vec_d[i] = (p_next == VEC_W'(i));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl     <= '0;
         pend    <= NONE;
         vec_req <= '0;
      end else begin
         lvl     <= irq_in;
         pend    <= p_next;
         vec_req <= vec_d;
      end
   end

   assert_single_line_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(vec_req));

   assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (vec_req == '0));

   assert_no_spontaneous_grant_R12: assert property (@(posedge clk) disable iff (rst)
      ((vec_req == '0) && !wr_en && (rise == '0)) |=> (vec_req == '0));

   assert_board_no_preempt_R10: assert property (@(posedge clk) disable iff (rst)
      ((vec_req != '0) && !wr_en && (rise[N_SLOT-1:0] == '0)) |=> $stable(vec_req));
endmodule

// File: tb/irq_vector_dispatch_test.sv
module irq_vector_dispatch_test;
   localparam int NONE_C = 65;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] irq_in = '0;
   logic        wr_en = 1'b0;
   logic [9:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [9:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [63:0] vec_req;

   int checks = 0;
   int errors = 0;

   logic [7:0]  m_se, n_se;
   logic [31:0] m_be, n_be;
   logic [63:0] m_lvl, n_lvl;
   int          m_pend, n_pend;

   irq_vector_dispatch uut (
      .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .vec_req(vec_req));

   always #10 clk = ~clk;

   function automatic logic [9:0] a_smap(int i); return {2'd0, 5'(i), 3'b100}; endfunction
   function automatic logic [9:0] a_bmap(int i); return {2'd1, 5'(i), 3'b100}; endfunction
   function automatic logic [9:0] a_sclr(int g); return {2'd2, 3'(g), 5'b00100}; endfunction
   function automatic logic [9:0] a_bclr(int n); return {2'd3, 5'(n), 3'b100}; endfunction

   function automatic logic [31:0] mread(logic [9:0] a);
      int idx = int'(a[7:3]);
      if (!a[2]) return 32'h0;
      case (a[9:8])
         2'd0: return (idx < 8) ? {m_se[idx], 31'(32'h7C0 | (idx * 4))} : 32'h0;
         2'd1: return {m_be[idx], 31'(32'h7E0 + idx)};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [63:0] mvec();
      return (m_pend == NONE_C) ? 64'h0 : (64'h1 << m_pend);
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_se = '0; m_be = '0; m_lvl = '0; m_pend = NONE_C;
   endtask

   task automatic model_step();
      int p = m_pend;
      bit run = 0;
      bit got = 0;
      int mi = int'(wr_addr[7:3]);
      int ci = int'(wr_addr[7:5]);
      n_se = m_se; n_be = m_be;
      if (wr_en && wr_addr[2]) begin
         case (wr_addr[9:8])
            2'd0: if (mi < 8) begin
               n_se[mi] = wr_data[31]; run = 1;
               if (!wr_data[31] && p == mi) p = NONE_C;
            end
            2'd1: begin
               n_be[mi] = wr_data[31]; run = 1;
               if (!wr_data[31] && p == mi + 32) p = NONE_C;
            end
            2'd2: if (p != NONE_C && p / 4 == ci) begin p = NONE_C; run = 1; end
            default: if (p == mi + 32) begin p = NONE_C; run = 1; end
         endcase
      end
      if (run && p == NONE_C) begin
         for (int i = 0; i < 64; i++) begin
            if (m_lvl[i] && ((i < 32) ? n_se[i/4] : n_be[i-32])) begin p = i; break; end
         end
      end
      for (int i = 0; i < 32; i++) begin
         if (irq_in[i] && !m_lvl[i] && n_se[i/4]) begin p = i; got = 1; break; end
      end
      if (!got && p == NONE_C) begin
         for (int i = 32; i < 64; i++) begin
            if (irq_in[i] && !m_lvl[i] && n_be[i-32]) begin p = i; break; end
         end
      end
      n_lvl = irq_in;
      n_pend = p;
   endtask

   task automatic tick(string vtag, string rtag);
      model_step();
      @(posedge clk);
      m_se = n_se; m_be = n_be; m_lvl = n_lvl; m_pend = n_pend;
      @(negedge clk);
      chk(vtag, vec_req, mvec());
      chk(rtag, {32'h0, rd_data}, {32'h0, mread(rd_addr)});
   endtask

   task automatic wr(logic [9:0] a, logic [31:0] d, string vtag, string rtag);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(vtag, rtag);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      do_reset();
      // R11: reset state; R2: fixed fields after reset
      chk("R11 reset lines", vec_req, 64'h0);
      rd_addr = a_smap(3); #1;
      chk("R2 slot group 3 readback", {32'h0, rd_data}, 64'h7CC);
      rd_addr = a_bmap(5); #1;
      chk("R2 board 5 readback", {32'h0, rd_data}, 64'h7E5);

      // R12: high but disabled levels grant nothing
      irq_in[40] = 1'b1; irq_in[9] = 1'b1;
      tick("R12 disabled rise", "R2");
      tick("R12 steady levels", "R2");
      rd_addr = a_bmap(8);
      wr(a_bmap(8), 32'h8000_0000, "R4 scan grants 40", "R2");
      chk("R4 expect 40", vec_req, 64'h1 << 40);
      rd_addr = a_smap(2);
      wr(a_smap(2), 32'h8000_0000, "R5 keeps 40", "R2");
      wr(a_bclr(7), 32'h0, "R8 mismatch clear", "R3");
      wr(a_bclr(8), 32'h0, "R8 exact clear rescans", "R3");
      chk("R8 expect 9", vec_req, 64'h1 << 9);
      wr(a_sclr(1), 32'h0, "R7 other group", "R3");
      irq_in[9] = 1'b0;
      tick("R7 level drop keeps", "R2");
      wr(a_sclr(2), 32'h0, "R7 group clear rescans", "R3");
      chk("R7 expect 40", vec_req, 64'h1 << 40);
      wr(a_bmap(8), 32'h0, "R6 board disable drops", "R2");
      chk("R6 expect idle", vec_req, 64'h0);
      irq_in[2] = 1'b1;
      tick("R12 group 0 off", "R2");
      wr(a_smap(0), 32'h8000_0000, "R4 scan grants 2", "R2");
      wr(a_smap(1), 32'h0, "R6 index mismatch", "R2");
      wr(a_smap(0), 32'h0, "R6 group off keeps 2", "R2");
      chk("R6 expect 2", vec_req, 64'h1 << 2);
      wr(a_smap(3), 32'h8000_0000, "R5 keeps 2", "R2");
      irq_in[13] = 1'b1;
      tick("R9 slot preempts", "R2");
      chk("R9 expect 13", vec_req, 64'h1 << 13);
      wr(a_smap(4), 32'h8000_0000, "R5", "R2");
      wr(a_smap(5), 32'h8000_0000, "R5", "R2");
      irq_in[20] = 1'b1; irq_in[17] = 1'b1;
      tick("R9 lowest of two", "R2");
      chk("R9 expect 17", vec_req, 64'h1 << 17);
      wr(a_bmap(12), 32'h8000_0000, "R5", "R2");
      irq_in[44] = 1'b1;
      tick("R10 board held off", "R2");
      chk("R10 expect 17", vec_req, 64'h1 << 17);
      irq_in = '0;
      tick("R1", "R2");
      wr(a_sclr(4), 32'h0, "R7 clear to idle", "R3");
      irq_in[44] = 1'b1;
      tick("R10 board grant", "R2");
      chk("R10 expect 44", vec_req, 64'h1 << 44);
      wr({2'd0, 5'd5, 3'b000}, 32'h0, "R3 even word write", "R3");
      rd_addr = a_smap(5); #1;
      chk("R3 enable kept", {32'h0, rd_data}, {32'h0, 32'h8000_07D4});
      rd_addr = {2'd0, 5'd5, 3'b000}; #1;
      chk("R3 even read zero", {32'h0, rd_data}, 64'h0);
      rd_addr = a_sclr(4); #1;
      chk("R3 clear region reads zero", {32'h0, rd_data}, 64'h0);

      // R11: reset in the middle of activity
      do_reset();
      chk("R11 lines after reset", vec_req, 64'h0);
      rd_addr = a_smap(5); #1;
      chk("R11 enable cleared", {32'h0, rd_data}, 64'h7D4);

      void'($urandom(32'd20240611));
      for (int c = 0; c < 4000; c++) begin
         if ($urandom_range(7) == 0) irq_in[$urandom_range(63)] ^= 1'b1;
         rd_addr = {2'($urandom_range(3)), 5'($urandom_range(31)), 1'($urandom_range(7) != 0), 2'b00};
         if ($urandom_range(3) == 0) begin
            wr({2'($urandom_range(3)), 5'($urandom_range(31)), 1'($urandom_range(7) != 0), 2'b00},
               {1'($urandom_range(1)), 31'($urandom())}, "R1 random", "R2 random");
         end else begin
            tick("R1 random", "R2 random");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule